// File: doc/BRIEF.md
# Dual-Clock FIFO with Runtime Almost Thresholds

This block is a first-in first-out buffer whose write port and read port run on two unrelated clocks. Words enter on the write clock while the write enable is held low and leave, through a registered output, on the read clock while the read enable is held low. Each pointer crosses into the opposite domain in Gray code through a two-stage synchroniser. The four active-low status outputs are therefore split by domain. Empty and almost-empty belong to the read clock. Full and almost-full belong to the write clock.

Back-pressure follows a plain valid/ready reading of the status pins. `full_n` high acts as ready for the writer. `empty_n` high acts as valid for the reader. An enable asserted against a low ready or valid is harmless and is dropped. The almost thresholds come from a separate offset register block as two input buses, so they can be changed while the buffer runs. An active-low retransmit strobe rewinds the read side to physical location zero, which lets a packet be replayed.

Top module: `dcf_fifo`

## Requirements
- R1: A write occurs on a rising `wclk` edge when `wen_n` is 0 and `full_n` is 1. With `full_n` at 0 the word is dropped and the stored contents are unchanged.
- R2: A read occurs on a rising `rclk` edge when `ren_n` is 0 and `empty_n` is 1. `dout` takes the oldest unread word at that same edge, and words leave in the order they were accepted.
- R3: While `empty_n` is 0 or `ren_n` is 1, `dout` keeps the last word validly read (zero if none since reset).
- R4: Once both clocks have run idle for a few cycles, `full_n` is 0 exactly when the stored word count equals the depth (2^AW).
- R5: Once both clocks have run idle for a few cycles, `empty_n` is 0 exactly when the word count is zero.
- R6: Once both clocks have run idle for a few cycles, `ae_n` is 0 when the count is at most `ae_lvl` and 1 when the count is at least `ae_lvl`+1. `ae_n` is never 1 while `empty_n` is 0.
- R7: Once both clocks have run idle for a few cycles, `af_n` is 0 when the count is at least depth minus `af_lvl` and 1 when the free space exceeds `af_lvl`. `af_n` is never 1 while `full_n` is 0.
- R8: While `rst_n` is 0 on both clocks, the block enters the empty state: `empty_n`=0, `ae_n`=0, `full_n`=1, `af_n`=1, `dout`=0.
- R9: `rt_n` at 0 on an `rclk` edge with `ren_n` at 1 returns the read pointer to location 0. Later reads replay every word written since reset, in order, and the flags follow the new pointer difference. Use is limited to at most depth writes since reset.
- R10: The write pointer seen by the read domain changes by at most one Gray bit per `wclk` edge. Flags derived from a synchronised pointer may clear late but never indicate room or data that does not exist.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rst_n | input | 1 | Active-low reset, sampled synchronously by each clock |
| wen_n | input | 1 | Active-low write enable |
| din | input | DW | Write data |
| rclk | input | 1 | Read clock |
| ren_n | input | 1 | Active-low read enable |
| rt_n | input | 1 | Active-low retransmit strobe (read domain) |
| ae_lvl | input | AW | Almost-empty threshold n |
| af_lvl | input | AW | Almost-full threshold m |
| dout | output | DW | Registered read data |
| empty_n | output | 1 | Low when empty (read domain) |
| ae_n | output | 1 | Low when almost empty (read domain) |
| full_n | output | 1 | Low when full (write domain) |
| af_n | output | 1 | Low when almost full (write domain) |

## Verification
The buffer is first filled one word at a time, and the flags are read after each threshold crossing. This separates the n and n+1 count for almost-empty and the depth-m-1 and depth-m count for almost-full. Writes pushed against a full buffer and reads pulled from an empty one show whether dropped operations corrupt contents or the held output word. A partial drain followed by a retransmit shows whether the rewind replays from location zero and whether the flags are recomputed. A concurrent phase with irregular gaps on both clocks exercises the Gray crossing under traffic, and an ordered scoreboard compares every word read.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  localparam int DCF_DW     = 9;
  localparam int DCF_AW     = 10;
  localparam int DCF_STAGES = 2;
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W      = 4,
  parameter int STAGES = dcf_pkg::DCF_STAGES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
  parameter int DW = dcf_pkg::DCF_DW,
  parameter int AW = dcf_pkg::DCF_AW
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) cells[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= cells[raddr];
  end
endmodule

// File: rtl/dcf_wr_ctrl.sv
module dcf_wr_ctrl #(
  parameter int AW = dcf_pkg::DCF_AW,
  localparam int PW = AW + 1
) (
  input  logic          wclk,
  input  logic          rst_n,
  input  logic          wen_n,
  input  logic [PW-1:0] rgray_s,
  input  logic [AW-1:0] af_lvl,
  output logic          we,
  output logic [PW-1:0] wbin,
  output logic [PW-1:0] wgray,
  output logic          full_n,
  output logic          af_n
);
  localparam int DEPTH = 1 << AW;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] wbin_nx, rbin_s, cnt_nx;
  logic [PW:0]   af_sum;

  assign we      = !wen_n && full_n;
  assign wbin_nx = wbin + PW'(we);
  assign rbin_s  = g2b(rgray_s);
  assign cnt_nx  = wbin_nx - rbin_s;
  assign af_sum  = {1'b0, cnt_nx} + {2'b00, af_lvl};

  always_ff @(posedge wclk) begin
    if (!rst_n) begin
      wbin   <= '0;
      wgray  <= '0;
      full_n <= 1'b1;
      af_n   <= 1'b1;
    end else begin
      wbin   <= wbin_nx;
      wgray  <= wbin_nx ^ (wbin_nx >> 1);
      full_n <= (cnt_nx != PW'(DEPTH));
      af_n   <= (af_sum < (PW+1)'(DEPTH));
    end
  end
endmodule

// File: rtl/dcf_rd_ctrl.sv
module dcf_rd_ctrl #(
  parameter int AW = dcf_pkg::DCF_AW,
  localparam int PW = AW + 1
) (
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          ren_n,
  input  logic          rt_n,
  input  logic [PW-1:0] wgray_s,
  input  logic [AW-1:0] ae_lvl,
  output logic          re,
  output logic [PW-1:0] rbin,
  output logic [PW-1:0] rgray,
  output logic          empty_n,
  output logic          ae_n
);
  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic          rt_go;
  logic [PW-1:0] wbin_s, rewind, rbin_nx, cnt_nx;

  assign re     = !ren_n && empty_n;
  assign rt_go  = !rt_n && ren_n;
  assign wbin_s = g2b(wgray_s);
  // location 0 in the lap that keeps (write - read) within 0..DEPTH
  assign rewind = {wbin_s[PW-1] & (wbin_s[AW-1:0] != '0), {AW{1'b0}}};
  assign rbin_nx = rt_go ? rewind : rbin + PW'(re);
  assign cnt_nx  = wbin_s - rbin_nx;

  always_ff @(posedge rclk) begin
    if (!rst_n) begin
      rbin    <= '0;
      rgray   <= '0;
      empty_n <= 1'b0;
      ae_n    <= 1'b0;
    end else begin
      rbin    <= rbin_nx;
      rgray   <= rbin_nx ^ (rbin_nx >> 1);
      empty_n <= (cnt_nx != '0);
      ae_n    <= (cnt_nx > {1'b0, ae_lvl});
    end
  end
endmodule

// File: rtl/dcf_fifo.sv
module dcf_fifo #(
  parameter int DW = dcf_pkg::DCF_DW,
  parameter int AW = dcf_pkg::DCF_AW
) (
  input  logic          wclk,
  input  logic          rst_n,
  input  logic          wen_n,
  input  logic [DW-1:0] din,
  input  logic          rclk,
  input  logic          ren_n,
  input  logic          rt_n,
  input  logic [AW-1:0] ae_lvl,
  input  logic [AW-1:0] af_lvl,
  output logic [DW-1:0] dout,
  output logic          empty_n,
  output logic          ae_n,
  output logic          full_n,
  output logic          af_n
);
  localparam int PW = AW + 1;

  logic          we, re;
  logic [PW-1:0] wbin, wgray, rbin, rgray, wgray_s, rgray_s;

  dcf_wr_ctrl #(.AW(AW)) u_wr (
    .wclk(wclk), .rst_n(rst_n), .wen_n(wen_n), .rgray_s(rgray_s),
    .af_lvl(af_lvl), .we(we), .wbin(wbin), .wgray(wgray),
    .full_n(full_n), .af_n(af_n)
  );

  dcf_rd_ctrl #(.AW(AW)) u_rd (
    .rclk(rclk), .rst_n(rst_n), .ren_n(ren_n), .rt_n(rt_n),
    .wgray_s(wgray_s), .ae_lvl(ae_lvl), .re(re), .rbin(rbin),
    .rgray(rgray), .empty_n(empty_n), .ae_n(ae_n)
  );

  dcf_sync #(.W(PW)) u_w2r (.clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_s));
  dcf_sync #(.W(PW)) u_r2w (.clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_s));

  dcf_mem #(.DW(DW), .AW(AW)) u_mem (
    .wclk(wclk), .we(we), .waddr(wbin[AW-1:0]), .wdata(din),
    .rclk(rclk), .rst_n(rst_n), .re(re), .raddr(rbin[AW-1:0]), .rdata(dout)
  );
endmodule

// File: rtl/dcf_fifo_chk.sv
module dcf_fifo_chk #(
  parameter int DW = dcf_pkg::DCF_DW,
  parameter int AW = dcf_pkg::DCF_AW,
  localparam int PW = AW + 1
) (
  input logic          wclk,
  input logic          rclk,
  input logic          rst_n,
  input logic          ren_n,
  input logic          rt_n,
  input logic          full_n,
  input logic          af_n,
  input logic          empty_n,
  input logic          ae_n,
  input logic [DW-1:0] dout,
  input logic [PW-1:0] wbin,
  input logic [PW-1:0] rbin,
  input logic [PW-1:0] wgray
);
  p_no_overflow_r1: assert property (@(posedge wclk) disable iff (!rst_n)
    !full_n |=> $stable(wbin));

  p_no_underflow_r3: assert property (@(posedge rclk) disable iff (!rst_n)
    (!empty_n && rt_n) |=> $stable(rbin));

  p_dout_hold_r3: assert property (@(posedge rclk) disable iff (!rst_n)
    (!empty_n || ren_n) |=> $stable(dout));

  p_ae_under_empty_r6: assert property (@(posedge rclk) disable iff (!rst_n)
    !empty_n |-> !ae_n);

  p_af_under_full_r7: assert property (@(posedge wclk) disable iff (!rst_n)
    !full_n |-> !af_n);

  p_gray_step_r10: assert property (@(posedge wclk) disable iff (!rst_n)
    $countones(wgray ^ $past(wgray)) <= 1);
endmodule

bind dcf_fifo dcf_fifo_chk #(.DW(DW), .AW(AW)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .ren_n(ren_n), .rt_n(rt_n),
  .full_n(full_n), .af_n(af_n), .empty_n(empty_n), .ae_n(ae_n),
  .dout(dout), .wbin(wbin), .rbin(rbin), .wgray(wgray)
);

// File: tb/dcf_fifo_test.sv
module dcf_fifo_test;
  localparam int CLK_PERIOD = 10;
  localparam int RCLK_HALF  = 7;
  localparam int DW = 9;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;
  localparam int N_AE = 3;
  localparam int M_AF = 2;

  logic wclk = 0, rclk = 0, rst_n = 0;
  logic wen_n = 1, ren_n = 1, rt_n = 1;
  logic [DW-1:0] din = '0;
  logic [AW-1:0] ae_lvl = AW'(N_AE), af_lvl = AW'(M_AF);
  logic [DW-1:0] dout;
  logic empty_n, ae_n, full_n, af_n;

  int total = 0, bad = 0, rd_cnt = 0;
  bit done = 0;
  logic [DW-1:0] exp_q[$];
  logic [DW-1:0] hist[$];

  always #(CLK_PERIOD/2) wclk = ~wclk;
  always #(RCLK_HALF) rclk = ~rclk;

  dcf_fifo #(.DW(DW), .AW(AW)) uut (
    .wclk(wclk), .rst_n(rst_n), .wen_n(wen_n), .din(din),
    .rclk(rclk), .ren_n(ren_n), .rt_n(rt_n), .ae_lvl(ae_lvl), .af_lvl(af_lvl),
    .dout(dout), .empty_n(empty_n), .ae_n(ae_n), .full_n(full_n), .af_n(af_n)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [DW-1:0] d, output bit acc);
    @(negedge wclk);
    wen_n = 0; din = d;
    #1 acc = full_n;
    if (acc) begin exp_q.push_back(d); hist.push_back(d); end
    @(posedge wclk);
    #1 wen_n = 1;
  endtask

  task automatic wr_n(input int cnt, input int base);
    bit a;
    for (int i = 0; i < cnt; i++) wr(DW'(base + i * 13), a);
  endtask

  task automatic rd();
    @(negedge rclk);
    ren_n = 0;
    @(posedge rclk);
    #1 ren_n = 1;
  endtask

  task automatic settle();
    repeat (8) @(negedge rclk);
    repeat (8) @(negedge wclk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (6) @(negedge rclk);
    repeat (6) @(negedge wclk);
    exp_q.delete(); hist.delete();
    rst_n = 1;
    #1;
  endtask

  // monitor: scoreboard pop on every read that the ports say happened
  initial begin
    bit fire;
    logic [DW-1:0] e;
    forever begin
      @(negedge rclk);
      #2 fire = !ren_n && empty_n && rst_n;
      @(posedge rclk);
      #1;
      if (fire) begin
        rd_cnt++;
        if (exp_q.size() == 0) chk("R2 read with nothing expected", 1, 0);
        else begin
          e = exp_q.pop_front();
          chk("R2 read order", int'(dout), int'(e));
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit a;
    int tgt;
    // R8 reset state
    repeat (6) @(negedge wclk);
    chk("R8 empty_n", empty_n, 0);
    chk("R8 ae_n", ae_n, 0);
    chk("R8 full_n", full_n, 1);
    chk("R8 af_n", af_n, 1);
    chk("R8 dout", int'(dout), 0);
    rst_n = 1;
    // R3 reads on empty ignored
    repeat (3) rd();
    settle();
    chk("R3 dout after empty reads", int'(dout), 0);
    chk("R5 empty_n at zero", empty_n, 0);
    // R6 thresholds: count 3 then 4
    wr_n(3, 9'h011);
    settle();
    chk("R5 empty_n at three", empty_n, 1);
    chk("R6 ae_n at n", ae_n, 0);
    wr_n(1, 9'h0A0);
    settle();
    chk("R6 ae_n at n+1", ae_n, 1);
    // R7 thresholds: count 13 then 14
    wr_n(9, 9'h100);
    settle();
    chk("R7 af_n at depth-m-1", af_n, 1);
    wr_n(1, 9'h055);
    settle();
    chk("R7 af_n at depth-m", af_n, 0);
    chk("R4 full_n at depth-m", full_n, 1);
    // R4 full, R1 dropped writes
    wr_n(2, 9'h0C3);
    settle();
    chk("R4 full_n at depth", full_n, 0);
    wr(9'h1FF, a);
    chk("R1 write accepted while full", a, 0);
    wr(9'h1FE, a);
    settle();
    chk("R4 full_n after dropped writes", full_n, 0);
    chk("R1 queued words", exp_q.size(), DEPTH);
    // drain
    repeat (DEPTH) rd();
    settle();
    chk("R2 all words read", exp_q.size(), 0);
    chk("R5 empty_n after drain", empty_n, 0);
    chk("R6 ae_n after drain", ae_n, 0);
    chk("R7 af_n after drain", af_n, 1);
    chk("R4 full_n after drain", full_n, 1);
    chk("R3 dout holds last", int'(dout), int'(hist[DEPTH-1]));
    repeat (2) rd();
    settle();
    chk("R3 dout after extra reads", int'(dout), int'(hist[DEPTH-1]));
    // R9 retransmit
    do_reset();
    chk("R8 dout after second reset", int'(dout), 0);
    wr_n(5, 9'h031);
    settle();
    repeat (3) rd();
    settle();
    chk("R9 ae_n before rewind", ae_n, 0);
    @(negedge rclk);
    rt_n = 0;
    @(posedge rclk);
    #1 rt_n = 1;
    exp_q = hist;
    settle();
    chk("R9 empty_n after rewind", empty_n, 1);
    chk("R9 ae_n after rewind", ae_n, 1);
    repeat (5) rd();
    settle();
    chk("R9 replay consumed", exp_q.size(), 0);
    chk("R9 empty_n after replay", empty_n, 0);
    chk("R9 dout last replayed", int'(dout), int'(hist[4]));
    // R10 concurrent traffic across the crossing
    tgt = rd_cnt + 40;
    fork
      begin
        for (int i = 0; i < 40; i++) begin
          a = 0;
          while (!a) wr(DW'(i * 37 + 5), a);
          if (i % 4 == 3) repeat (3) @(negedge wclk);
        end
      end
      begin
        int k = 0;
        while (rd_cnt < tgt) begin
          rd();
          k++;
          if (k % 5 == 2) repeat (2) @(negedge rclk);
        end
      end
    join
    settle();
    chk("R10 stream fully drained", exp_q.size(), 0);
    chk("R10 empty_n after stream", empty_n, 0);
    chk("R10 full_n after stream", full_n, 1);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule